// File: doc/BRIEF.md
# Address Translation Cache with Page-Table Refill

This block turns virtual addresses from a processor-side request port into physical addresses. It keeps a fully associative set of recent translations. Every stored entry is compared with the incoming virtual page number in the same cycle. On a hit, the page-offset bits are carried through unchanged and the physical page number replaces the virtual one. The physical page number is narrower than the virtual page number.

On a miss, the block reads one page-table entry from memory. The address of that entry is the table base input plus the virtual page number times the entry size. If the fetched entry is marked present, it is written into a free slot, or into the slot chosen by a rotating pointer, and the lookup runs again. If it is not present, the request ends with a page fault and nothing is stored. A write to a page whose entry does not allow writes ends with a protection fault.

A flush input drops every stored translation in one cycle. Only one request is handled at a time.

Top module: `tlb_refill`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_done` and `mem_rd_req` are 0. No translation is stored, so the first request to any page causes a memory read.
- R2: A successful completion returns `rsp_paddr` = {physical page number, the request's low OFF_W address bits}, with the offset bits unchanged.
- R3: A request whose page is stored completes without any memory read. `rsp_done` is seen one clock after the clock edge that accepted the request.
- R4: On a miss, `mem_rd_req` rises with `mem_rd_addr` = `pt_base` + virtual page number × PTE_BYTES. Both stay unchanged until the cycle in which `mem_rd_ack` is 1.
- R5: The fetched entry `mem_rd_data` is laid out as follows: bit 0 is present, bit 1 is write-allowed, and bits [PPN_W+1:2] are the physical page number. A present entry is stored, and the request is replayed and completes with that translation.
- R6: A non-present fetched entry completes the request with `rsp_fault`=1 and `rsp_cause`=2'b01. It is not stored, so the next request to that page reads memory again.
- R7: A write request (`req_write`=1) to a page whose write-allowed bit is 0 completes with `rsp_fault`=1 and `rsp_cause`=2'b10. This holds whether the translation was stored or freshly fetched. Read requests to such pages succeed. A completion without a fault has `rsp_cause`=2'b00.
- R8: A refill uses the lowest-numbered empty slot if there is one. Otherwise it uses the slot named by a rotating pointer, which then advances by one and wraps. Reset and flush set the pointer to slot 0.
- R9: A `flush` pulse removes every stored translation in one cycle. A request accepted in the same cycle as a flush is handled as a miss.
- R10: `req_ready` is 0 from the cycle after acceptance until `rsp_done` is given. `rsp_done` is a one-cycle pulse for every request.
- R11: No two stored slots ever match the same virtual page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all stored translations |
| pt_base | input | MEM_AW | Byte address of the page table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_paddr | output | PA_W | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Request ended in a fault |
| rsp_cause | output | 2 | 00 none, 01 page absent, 10 write not allowed |
| mem_rd_req | output | 1 | Page-table read request, held until ack |
| mem_rd_addr | output | MEM_AW | Byte address of the page-table entry |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | PA_W-OFF_W+2 | Page-table entry |

## Verification
A read sweep over every virtual page of a 256-page configuration separates present pages, which must translate, from absent pages, which must fault. Every page's table-entry address is checked as well. A write sweep then adds write-protected pages, so all three cause codes are exercised. Replaying the most recently filled pages shows which translations were kept, because hits show no memory read and have a one-cycle latency. A fill-past-capacity sequence tells the empty-slot-first choice apart from rotating eviction. Flushes, both while idle and in the cycle a request is accepted, must force fresh table reads.

// File: rtl/tlb_refill_pkg.sv
package tlb_refill_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PAGE = 2'b01,
    CAUSE_PROT = 2'b10
  } fault_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WALK
  } walk_state_e;

  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_WRITE_BIT   = 1;
  localparam int PTE_PPN_LSB     = 2;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               fill_we,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic               hit_we
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic               we_q  [ENTRIES];

  // valid bits: reset and flush clear all, flush wins over a same-cycle fill
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
    end
  end

  // payload storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_vpn;
      ppn_q[fill_idx] <= fill_ppn;
      we_q[fill_idx]  <= fill_we;
    end
  end

  // parallel compare of every slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    hit_we  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_we  = hit_we | we_q[i];
      end
    end
  end

  assign hit       = |match_vec;
  assign valid_vec = valid_q;

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  // lowest-numbered empty slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = free_any ? free_idx : rr_q;

  // rotating pointer moves only when it was the one used
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rr_q <= '0;
    end else if (take && !free_any) begin
      rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl
  import tlb_refill_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int PPN_W     = 16,
  parameter int MEM_AW    = 32,
  parameter int PTE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    req_ready,
  input  logic [MEM_AW-1:0]       pt_base,
  output logic [VA_W-OFF_W-1:0]   lk_vpn,
  input  logic                    hit,
  input  logic [PPN_W-1:0]        hit_ppn,
  input  logic                    hit_we,
  output logic                    fill_en,
  output logic [PPN_W-1:0]        fill_ppn,
  output logic                    fill_we,
  output logic                    mem_rd_req,
  output logic [MEM_AW-1:0]       mem_rd_addr,
  input  logic                    mem_rd_ack,
  input  logic [PPN_W+1:0]        mem_rd_data,
  output logic                    rsp_done,
  output logic [PPN_W+OFF_W-1:0]  rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause
);

  localparam int PTE_SH = $clog2(PTE_BYTES);

  walk_state_e       state_q;
  logic [VA_W-1:0]   vaddr_q;
  logic              write_q;
  logic              hit_eff;
  logic              pte_present;
  logic [OFF_W-1:0]  offset;
  logic [MEM_AW-1:0] pte_addr;

  assign lk_vpn      = vaddr_q[VA_W-1:OFF_W];
  assign offset      = vaddr_q[OFF_W-1:0];
  assign hit_eff     = hit && !flush;
  assign pte_present = mem_rd_data[PTE_PRESENT_BIT];
  assign fill_ppn    = mem_rd_data[PTE_PPN_LSB +: PPN_W];
  assign fill_we     = mem_rd_data[PTE_WRITE_BIT];
  assign fill_en     = (state_q == ST_WALK) && mem_rd_ack && pte_present;
  assign req_ready   = (state_q == ST_IDLE);
  assign pte_addr    = pt_base + (MEM_AW'(lk_vpn) << PTE_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      write_q     <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rsp_done    <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= 1'b0;
      rsp_cause   <= CAUSE_NONE;
    end else begin
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            write_q <= req_write;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit_eff) begin
            rsp_done <= 1'b1;
            state_q  <= ST_IDLE;
            if (write_q && !hit_we) begin
              rsp_fault <= 1'b1;
              rsp_cause <= CAUSE_PROT;
              rsp_paddr <= '0;
            end else begin
              rsp_paddr <= {hit_ppn, offset};
            end
          end else begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= pte_addr;
            state_q     <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (mem_rd_ack) begin
            mem_rd_req <= 1'b0;
            if (pte_present) begin
              state_q <= ST_LOOKUP;
            end else begin
              rsp_done  <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_cause <= CAUSE_PAGE;
              rsp_paddr <= '0;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlb_refill.sv
module tlb_refill #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 28,
  parameter int OFF_W     = 12,
  parameter int ENTRIES   = 32,
  parameter int MEM_AW    = 32,
  parameter int PTE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [MEM_AW-1:0]       pt_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    req_write,
  output logic                    rsp_done,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause,
  output logic                    mem_rd_req,
  output logic [MEM_AW-1:0]       mem_rd_addr,
  input  logic                    mem_rd_ack,
  input  logic [PA_W-OFF_W+1:0]   mem_rd_data
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   lk_vpn;
  logic               hit;
  logic [PPN_W-1:0]   hit_ppn;
  logic               hit_we;
  logic               fill_en;
  logic [PPN_W-1:0]   fill_ppn;
  logic               fill_we;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;

  tlb_walk_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
    .MEM_AW(MEM_AW), .PTE_BYTES(PTE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .pt_base(pt_base), .lk_vpn(lk_vpn),
    .hit(hit), .hit_ppn(hit_ppn), .hit_we(hit_we),
    .fill_en(fill_en), .fill_ppn(fill_ppn), .fill_we(fill_we),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst(rst), .flush(flush), .lk_vpn(lk_vpn),
    .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(lk_vpn),
    .fill_ppn(fill_ppn), .fill_we(fill_we),
    .valid_vec(valid_vec), .match_vec(match_vec),
    .hit(hit), .hit_ppn(hit_ppn), .hit_we(hit_we)
  );

  tlb_victim_sel #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .valid_vec(valid_vec),
    .take(fill_en), .victim_idx(victim_idx)
  );

endmodule

// File: rtl/tlb_refill_chk.sv
module tlb_refill_chk #(
  parameter int OFF_W   = 12,
  parameter int PA_W    = 28,
  parameter int ENTRIES = 32,
  parameter int MEM_AW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [OFF_W-1:0]   req_off,
  input logic               rsp_done,
  input logic               rsp_fault,
  input logic [1:0]         rsp_cause,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               mem_rd_req,
  input logic               mem_rd_ack,
  input logic [MEM_AW-1:0]  mem_rd_addr,
  input logic [ENTRIES-1:0] match_vec
);

  logic [OFF_W-1:0] off_cap;

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) off_cap <= req_off;
  end

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(!req_ready));

  a_r7_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_fault) |-> (rsp_cause == 2'b01 || rsp_cause == 2'b10));

  a_r7_clean_no_cause: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && !rsp_fault) |-> (rsp_cause == 2'b00));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_cap));

  a_r4_read_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_req);

  a_r11_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

endmodule

bind tlb_refill tlb_refill_chk #(
  .OFF_W(OFF_W), .PA_W(PA_W), .ENTRIES(ENTRIES), .MEM_AW(MEM_AW)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_vaddr[OFF_W-1:0]), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .mem_rd_req(mem_rd_req),
  .mem_rd_ack(mem_rd_ack), .mem_rd_addr(mem_rd_addr), .match_vec(match_vec)
);

// File: tb/tlb_refill_bench.sv
`timescale 1ns/1ps
module tlb_refill_bench;

  localparam int VA_W = 20, PA_W = 18, OFF_W = 12, ENTRIES = 16, MEM_AW = 32;
  localparam int VPN_W = VA_W - OFF_W, PPN_W = PA_W - OFF_W, LAT = 2;
  localparam int PAGES = 1 << VPN_W;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic [MEM_AW-1:0] pt_base = 32'h1000_0000;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, rsp_done, rsp_fault, mem_rd_req;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_cause;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic mem_rd_ack = 1'b0;
  logic [PPN_W+1:0] mem_rd_data = '0;

  int total = 0, bad = 0, walks = 0, salt = 0, cur_vpn = 0, wcnt = 0;

  tlb_refill #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES),
               .MEM_AW(MEM_AW), .PTE_BYTES(4)) u_tlb_refill (
    .clk(clk), .rst(rst), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  always #4 clk = ~clk;

  function automatic bit pg_present(int v); return (v % 7) != 3; endfunction
  function automatic bit pg_write(int v);   return (v % 3) != 0; endfunction
  function automatic int pg_ppn(int v);     return (v * 5 + salt) % (1 << PPN_W); endfunction
  function automatic int pg_off(int v);     return (v * 37 + 5) % (1 << OFF_W); endfunction

  task automatic chk(string rq, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // page-table memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_ack) begin
        mem_rd_ack = 1'b0;
      end else if (mem_rd_req) begin
        if (wcnt == LAT) begin
          wcnt = 0;
          chk("R4", "entry address", mem_rd_addr, pt_base + MEM_AW'(cur_vpn * 4));
          mem_rd_data = {PPN_W'(pg_ppn(cur_vpn)), pg_write(cur_vpn), pg_present(cur_vpn)};
          mem_rd_ack  = 1'b1;
          walks++;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic access(input int v, input bit wr, input bit fl,
                        output int cause, output int pa, output int nwalk, output int lat);
    int w0;
    int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_vpn   = v;
    req_vaddr = {VPN_W'(v), OFF_W'(pg_off(v))};
    req_write = wr;
    req_valid = 1'b1;
    flush     = fl;
    w0        = walks;
    @(negedge clk);
    req_valid = 1'b0;
    flush     = 1'b0;
    chk("R10", "ready while busy", req_ready, 0);
    cyc = 0;
    while (!rsp_done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10", "completion seen", rsp_done, 1);
    cause = rsp_fault ? int'(rsp_cause) + 4 : int'(rsp_cause);
    pa    = int'(rsp_paddr);
    nwalk = walks - w0;
    lat   = cyc;
    @(negedge clk);
    chk("R10", "done pulse width", rsp_done, 0);
  endtask

  // cause encoding here: 0 clean, 5 = fault+page, 6 = fault+protection
  task automatic run(string rq, input int v, input bit wr, input bit fl, input int exp_walk);
    int cause, pa, nw, lat, ec;
    access(v, wr, fl, cause, pa, nw, lat);
    ec = !pg_present(v) ? 5 : (wr && !pg_write(v)) ? 6 : 0;
    chk(rq, "fault/cause", cause, ec);
    chk(rq, "table reads", nw, exp_walk);
    if (ec == 0) chk("R2", "physical address", pa, pg_ppn(v) * (1 << OFF_W) + pg_off(v));
    if (exp_walk == 0) chk("R3", "hit latency", lat, 1);
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lst[ENTRIES];
    int a[ENTRIES + 2];
    int n;
    int pv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "done after reset", rsp_done, 0);
    chk("R1", "mem read after reset", mem_rd_req, 0);

    // read sweep over every page: each is a miss (R1, R5, R6)
    for (int v = 0; v < PAGES; v++) run(pg_present(v) ? "R5" : "R6", v, 1'b0, 1'b0, 1);

    // the last ENTRIES present pages must still be stored
    n = 0;
    for (int v = PAGES - 1; v >= 0 && n < ENTRIES; v--)
      if (pg_present(v)) begin lst[n] = v; n++; end
    for (int i = 0; i < ENTRIES; i++) run("R3", lst[i], 1'b0, 1'b0, 0);

    // absent page was not stored
    run("R6", 3, 1'b0, 1'b0, 1);

    // write permission on stored translations
    pv = -1;
    for (int i = 0; i < ENTRIES; i++) if (!pg_write(lst[i]) && pv < 0) pv = lst[i];
    run("R7", pv, 1'b1, 1'b0, 0);
    pv = -1;
    for (int i = 0; i < ENTRIES; i++) if (pg_write(lst[i]) && pv < 0) pv = lst[i];
    run("R7", pv, 1'b1, 1'b0, 0);
    run("R7", 6, 1'b1, 1'b0, 1);

    // flush while idle, then flush in accept cycle
    pulse_flush();
    run("R9", pv, 1'b0, 1'b0, 1);
    run("R9", pv, 1'b0, 1'b1, 1);

    // replacement order with a new table (R8)
    pulse_flush();
    pt_base = 32'h0004_0000;
    salt = 9;
    n = 0;
    for (int v = 100; n < ENTRIES + 2; v++)
      if (pg_present(v)) begin a[n] = v; n++; end
    for (int i = 0; i < ENTRIES + 2; i++) run("R8", a[i], 1'b0, 1'b0, 1);
    run("R8", a[ENTRIES - 1], 1'b0, 1'b0, 0);
    run("R8", a[2], 1'b0, 1'b0, 0);
    run("R8", a[ENTRIES], 1'b0, 1'b0, 0);
    run("R8", a[0], 1'b0, 1'b0, 1);
    run("R8", a[1], 1'b0, 1'b0, 1);
    run("R8", a[4], 1'b0, 1'b0, 0);
    run("R8", a[2], 1'b0, 1'b0, 1);

    // write sweep after a flush: all three outcomes
    pulse_flush();
    for (int v = 0; v < PAGES; v++) run("R7", v, 1'b1, 1'b0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule